// File: doc/BRIEF.md
# Pre and Post Event Capture Buffer

This block records a sample stream around an event so that both the history leading up to the event and what followed it are kept. It holds `DEPTH` words, 1024 by default. When the trigger window first goes high, the block samples a programmed pre-event count. From then on every valid sample is stored.

Once the stored count reaches that number, each new sample pushes out the oldest one. Before the event the buffer therefore acts as a fixed-length delay line. The event is the trigger window going low. At that point discarding stops, and samples keep arriving until the buffer is full. A done output then rises and the buffer freezes.

A host drains the captured words in arrival order through a show-ahead read port. An empty flag marks the end of the readout. A clear input returns the block to idle at any time.

Top module: `trig_capture_buf`

## Requirements
- R1: After reset, or in the cycle after `clr` is high in any state, `cap_done` is 0, `host_empty` is 1 and `host_data` is zero. `clr` takes priority over every other input.
- R2: While idle (no capture started since reset or clear), valid samples and a low `trig_win` write nothing, and `host_empty` stays 1.
- R3: The threshold is taken from `pre_cnt` in the idle cycle where `trig_win` is seen high. A value of 0 is treated as 1. Changes to `pre_cnt` after that cycle have no effect until the next clear.
- R4: Before the event (`trig_win` still high), every valid sample is stored. When the stored count already equals the threshold, the same edge also drops the oldest word, so the count never exceeds the threshold.
- R5: The first cycle with `trig_win` low after a capture started is the event. A valid sample in that cycle is stored as the first post-event word, and no word is dropped in it.
- R6: After the event, valid samples are stored without dropping until `DEPTH` words are held. `cap_done` is 1 from the cycle after the filling edge, and later samples are ignored.
- R7: While `cap_done` is 1 and the buffer is not empty, `host_data` shows the oldest word and a high `host_rd` removes it at the clock edge. A `host_rd` while empty does nothing. `host_empty` rises after the last word is removed.
- R8: A finished capture reads out as the last min(threshold, pre-event samples) pre-event samples followed by the post-event samples, all in arrival order, `DEPTH` words in total.
- R9: Before `cap_done`, `host_rd` removes nothing and `host_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all state |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous return to idle, buffer emptied |
| smp_data | input | DATA_W | Sample word |
| smp_vld | input | 1 | Sample word is valid this cycle |
| trig_win | input | 1 | High arms the capture; its fall is the event |
| pre_cnt | input | $clog2(DEPTH) | Number of pre-event words to keep (1 to DEPTH-1) |
| host_rd | input | 1 | Pop the oldest captured word |
| host_data | output | DATA_W | Oldest captured word, zero unless done and not empty |
| host_empty | output | 1 | No words held |
| cap_done | output | 1 | Capture complete, buffer frozen for readout |

## Verification
Two collisions matter. The first is the event landing on a cycle that also carries a valid sample. That sample must be kept without a drop, while its neighbour one cycle earlier was stored with a drop. The second is that same event write filling the buffer when the threshold is `DEPTH-1`, so the event and the full condition fall on one edge.

The bench forces both collisions with directed trigger edges inside otherwise random valid patterns. It judges them by draining the buffer and comparing every word against a reference queue that follows the requirement rules.

// File: rtl/tcb_pkg.sv
package tcb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_POST = 2'd2,
    ST_DONE = 2'd3
  } cap_state_e;
endpackage

// File: rtl/tcb_store.sv
module tcb_store #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 1024,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [DEPTH];

  // storage rows carry no reset; content is only ever read behind valid occupancy
  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/tcb_ptrs.sv
module tcb_ptrs #(
  parameter int DEPTH = 1024,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_en,
  input  logic          pop_en,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic [CW-1:0] occ
);
  localparam logic [AW-1:0] LAST_ROW = AW'(DEPTH - 1);

  logic [AW-1:0] wr_ptr_nxt;
  logic [AW-1:0] rd_ptr_nxt;
  logic [CW-1:0] occ_nxt;

  always_comb begin
    wr_ptr_nxt = wr_ptr;
    rd_ptr_nxt = rd_ptr;
    occ_nxt    = occ;
    if (clr) begin
      wr_ptr_nxt = '0;
      rd_ptr_nxt = '0;
      occ_nxt    = '0;
    end else begin
      if (wr_en) begin
        wr_ptr_nxt = (wr_ptr == LAST_ROW) ? '0 : wr_ptr + AW'(1);
      end
      if (pop_en) begin
        rd_ptr_nxt = (rd_ptr == LAST_ROW) ? '0 : rd_ptr + AW'(1);
      end
      occ_nxt = occ + CW'(wr_en) - CW'(pop_en);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else begin
      wr_ptr <= wr_ptr_nxt;
      rd_ptr <= rd_ptr_nxt;
      occ    <= occ_nxt;
    end
  end
endmodule

// File: rtl/tcb_ctrl.sv
module tcb_ctrl
  import tcb_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          trig_win,
  input  logic          smp_vld,
  input  logic          host_rd,
  input  logic [AW-1:0] pre_cnt,
  input  logic [CW-1:0] occ,
  output cap_state_e    state,
  output logic [AW-1:0] thr,
  output logic          wr_en,
  output logic          pop_en
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [CW-1:0] MAX_THR  = CW'(DEPTH - 1);

  cap_state_e    state_nxt;
  logic [AW-1:0] thr_nxt;
  logic          thr_ld;
  logic [AW-1:0] pre_legal;
  logic          drop_oldest;
  logic          host_pop;
  logic [CW-1:0] occ_after;

  // clamp the programmed pre-event count into 1 .. DEPTH-1
  always_comb begin
    if (pre_cnt == '0) begin
      pre_legal = AW'(1);
    end else if ({1'b0, pre_cnt} > MAX_THR) begin
      pre_legal = AW'(DEPTH - 1);
    end else begin
      pre_legal = pre_cnt;
    end
  end

  // write latch (pre/post states), window-gated drop path, host pop
  always_comb begin
    wr_en       = 1'b0;
    drop_oldest = 1'b0;
    host_pop    = 1'b0;
    if (!clr) begin
      unique case (state)
        ST_PRE:  begin
          wr_en       = smp_vld;
          drop_oldest = smp_vld & trig_win & (occ == {1'b0, thr});
        end
        ST_POST: wr_en    = smp_vld & (occ != FULL_CNT);
        ST_DONE: host_pop = host_rd & (occ != '0);
        default: ;
      endcase
    end
    pop_en    = drop_oldest | host_pop;
    occ_after = occ + CW'(wr_en) - CW'(pop_en);
  end

  always_comb begin
    state_nxt = state;
    thr_nxt   = thr;
    thr_ld    = 1'b0;
    if (clr) begin
      state_nxt = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (trig_win) begin
            state_nxt = ST_PRE;
            thr_nxt   = pre_legal;
            thr_ld    = 1'b1;
          end
        end
        ST_PRE: begin
          if (!trig_win) begin
            state_nxt = (occ_after == FULL_CNT) ? ST_DONE : ST_POST;
          end
        end
        ST_POST: begin
          if (occ_after == FULL_CNT) begin
            state_nxt = ST_DONE;
          end
        end
        default: state_nxt = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
    end else begin
      state <= state_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr <= AW'(1);
    end else if (thr_ld) begin
      thr <= thr_nxt;
    end
  end
endmodule

// File: rtl/trig_capture_buf.sv
module trig_capture_buf
  import tcb_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 1024
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic [DATA_W-1:0]        smp_data,
  input  logic                     smp_vld,
  input  logic                     trig_win,
  input  logic [$clog2(DEPTH)-1:0] pre_cnt,
  input  logic                     host_rd,
  output logic [DATA_W-1:0]        host_data,
  output logic                     host_empty,
  output logic                     cap_done
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  cap_state_e        cap_state;
  logic [AW-1:0]     thr;
  logic              wr_en;
  logic              pop_en;
  logic [AW-1:0]     wr_ptr;
  logic [AW-1:0]     rd_ptr;
  logic [CW-1:0]     occ;
  logic [DATA_W-1:0] head_word;

  tcb_ctrl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .trig_win (trig_win),
    .smp_vld  (smp_vld),
    .host_rd  (host_rd),
    .pre_cnt  (pre_cnt),
    .occ      (occ),
    .state    (cap_state),
    .thr      (thr),
    .wr_en    (wr_en),
    .pop_en   (pop_en)
  );

  tcb_ptrs #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ptrs (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (clr),
    .wr_en  (wr_en),
    .pop_en (pop_en),
    .wr_ptr (wr_ptr),
    .rd_ptr (rd_ptr),
    .occ    (occ)
  );

  tcb_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_store (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_ptr),
    .wr_data (smp_data),
    .rd_addr (rd_ptr),
    .rd_data (head_word)
  );

  assign cap_done   = (cap_state == ST_DONE);
  assign host_empty = (occ == '0);
  assign host_data  = (cap_done && !host_empty) ? head_word : '0;
endmodule

// File: rtl/tcb_chk.sv
module tcb_chk #(
  parameter int DEPTH = 1024,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = AW + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clr,
  input logic          trig_win,
  input logic          host_rd,
  input logic          cap_done,
  input logic          host_empty,
  input logic [1:0]    state,
  input logic [CW-1:0] occ,
  input logic [AW-1:0] thr
);
  // occupancy bounded by the threshold while the window is still open
  assert_pre_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd1 && trig_win) |-> (occ <= {1'b0, thr}));

  // done rises only with a completely filled buffer
  assert_done_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cap_done) |-> (occ == CW'(DEPTH)));

  // a frozen buffer never grows
  assert_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_done && !clr) |=> (occ <= $past(occ)));

  // nothing is held while idle
  assert_idle_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd0) |-> host_empty);

  // clear lands in one edge
  assert_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!cap_done && host_empty));

  // threshold frozen once a capture started
  assert_thr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state != 2'd0 && !clr) |=> $stable(thr));

  // each accepted host read removes exactly one word
  assert_pop_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_done && host_rd && !host_empty && !clr) |=> (occ == $past(occ) - CW'(1)));
endmodule

bind trig_capture_buf tcb_chk #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .clr        (clr),
  .trig_win   (trig_win),
  .host_rd    (host_rd),
  .cap_done   (cap_done),
  .host_empty (host_empty),
  .state      (cap_state),
  .occ        (occ),
  .thr        (thr)
);

// File: tb/sim_trig_capture_buf.sv
module sim_trig_capture_buf;
  localparam int DW    = 16;
  localparam int DEPTH = 1024;
  localparam int AW    = $clog2(DEPTH);

  logic          clk;
  logic          rst_n;
  logic          clr;
  logic [DW-1:0] smp_data;
  logic          smp_vld;
  logic          trig_win;
  logic [AW-1:0] pre_cnt;
  logic          host_rd;
  logic [DW-1:0] host_data;
  logic          host_empty;
  logic          cap_done;

  trig_capture_buf #(.DATA_W(DW), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .smp_data(smp_data), .smp_vld(smp_vld),
    .trig_win(trig_win), .pre_cnt(pre_cnt), .host_rd(host_rd),
    .host_data(host_data), .host_empty(host_empty), .cap_done(cap_done)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // reference model: 0 idle, 1 pre, 2 post, 3 done
  int m_st = 0;
  int m_thr = 1;
  logic [DW-1:0] q[$];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog R6 actual=%0d expected<=%0d", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic int clamp_thr(int p);
    if (p == 0) return 1;
    if (p > DEPTH - 1) return DEPTH - 1;
    return p;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_update(bit v, logic [DW-1:0] d, bit w, bit rd, bit c, int pc);
    if (c) begin
      m_st = 0;
      q.delete();
    end else begin
      case (m_st)
        0: if (w) begin m_st = 1; m_thr = clamp_thr(pc); end
        1: begin
          if (v) begin
            q.push_back(d);
            if (w && q.size() > m_thr) void'(q.pop_front());
          end
          if (!w) begin
            m_st = 2;
            if (q.size() == DEPTH) m_st = 3;
          end
        end
        2: begin
          if (v && q.size() < DEPTH) q.push_back(d);
          if (q.size() == DEPTH) m_st = 3;
        end
        default: if (rd && q.size() > 0) void'(q.pop_front());
      endcase
    end
  endtask

  task automatic check_outputs(string tag);
    int exp_d;
    exp_d = (m_st == 3 && q.size() > 0) ? int'(q[0]) : 0;
    check(cap_done == (m_st == 3), {tag, " done"}, int'(cap_done), int'(m_st == 3));
    check(host_empty == (q.size() == 0), {tag, " empty"}, int'(host_empty), int'(q.size() == 0));
    check(int'(host_data) == exp_d, {tag, " data"}, int'(host_data), exp_d);
  endtask

  task automatic step(bit v, logic [DW-1:0] d, bit w, bit rd, bit c, string tag);
    int pc;
    smp_vld = v; smp_data = d; trig_win = w; host_rd = rd; clr = c;
    pc = int'(pre_cnt);
    @(posedge clk);
    model_update(v, d, w, rd, c, pc);
    #2;
    check_outputs(tag);
  endtask

  task automatic start_capture(int pc);
    pre_cnt = AW'(pc);
    step(1'b1, DW'($urandom), 1'b1, 1'b0, 1'b0, "R3");
  endtask

  task automatic pre_phase(int n, int pct);
    for (int i = 0; i < n; i++) begin
      step(($urandom % 100) < pct, DW'($urandom), 1'b1, $urandom % 2, 1'b0, "R4 R9");
    end
  endtask

  task automatic post_until_done(int pct);
    while (m_st != 3) begin
      step(($urandom % 100) < pct, DW'($urandom), 1'b0, $urandom % 2, 1'b0, "R6 R9");
    end
    for (int i = 0; i < 4; i++) step(1'b1, DW'($urandom), 1'b0, 1'b0, 1'b0, "R6");
  endtask

  task automatic readout();
    int n;
    n = 0;
    while (q.size() > 0) begin
      step(1'b0, '0, 1'b0, ($urandom % 3) != 0, 1'b0, "R8");
      n++;
    end
    for (int i = 0; i < 3; i++) step(1'b1, DW'($urandom), 1'b1, 1'b1, 1'b0, "R7");
  endtask

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; clr = 1'b0; smp_data = '0; smp_vld = 1'b0;
    trig_win = 1'b0; pre_cnt = '0; host_rd = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    rst_n = 1'b1;
    check_outputs("R1");

    // R2: idle traffic with window low writes nothing
    for (int i = 0; i < 40; i++) step($urandom % 2, DW'($urandom), 1'b0, $urandom % 2, 1'b0, "R2");

    // capture A: threshold 100, pre_cnt changed mid-capture (R3), event with sample (R5)
    start_capture(100);
    pre_phase(150, 75);
    pre_cnt = AW'(7);
    pre_phase(150, 75);
    step(1'b1, DW'($urandom), 1'b0, 1'b0, 1'b0, "R5");
    post_until_done(75);
    readout();

    // capture B: threshold 0 behaves as 1
    step(1'b0, '0, 1'b0, 1'b0, 1'b1, "R1");
    start_capture(0);
    pre_phase(30, 100);
    step(1'b1, DW'($urandom), 1'b0, 1'b0, 1'b0, "R5");
    post_until_done(90);
    readout();

    // capture C: threshold DEPTH-1, event sample fills the buffer on the same edge
    step(1'b0, '0, 1'b0, 1'b0, 1'b1, "R1");
    start_capture(DEPTH - 1);
    pre_phase(1100, 100);
    step(1'b1, DW'($urandom), 1'b0, 1'b0, 1'b0, "R5");
    check(cap_done == 1'b1, "R5 event fills", int'(cap_done), 1);
    post_until_done(50);
    readout();

    // capture D: fewer pre-event samples than the threshold, event without sample
    step(1'b0, '0, 1'b0, 1'b0, 1'b1, "R1");
    start_capture(500);
    pre_phase(20, 100);
    step(1'b0, '0, 1'b0, 1'b0, 1'b0, "R5");
    post_until_done(80);
    readout();

    // clear in the middle of post-event filling
    step(1'b0, '0, 1'b0, 1'b0, 1'b1, "R1");
    start_capture(64);
    pre_phase(100, 60);
    step(1'b1, DW'($urandom), 1'b0, 1'b0, 1'b0, "R5");
    for (int i = 0; i < 100; i++) step(1'b1, DW'($urandom), 1'b0, 1'b1, 1'b0, "R6 R9");
    step(1'b1, DW'($urandom), 1'b1, 1'b1, 1'b1, "R1");
    for (int i = 0; i < 10; i++) step(1'b1, DW'($urandom), 1'b0, 1'b0, 1'b0, "R2");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule